// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block picks which of several DMA channels is served next. A channel asks for service either through its hardware request line or through a request bit that software sets. The two sources are ORed, and a per-channel mask bit then gates the result. From the channels that are still eligible, the arbiter issues one registered one-hot grant with a valid flag. It holds that grant until the transfer engine reports that the service is complete. Only after that does it make a new decision.

The command byte supplies two controls. Bit 2 stops the controller from issuing any new grant. Bit 4 chooses between fixed and rotating priority. Both bit positions matter because the register decoder next to this block writes the command byte unchanged. The block also reports the raw per-channel request bits, which the register logic places in the upper nibble of the status byte. Bus cycles, address generation and register decoding sit outside this block.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros, `grant_valid` is 0, and the rotating start point is channel 0.
- R2: `grant` has at most one bit set, and `grant_valid` is 1 exactly when `grant` is nonzero.
- R3: When `cmd_byte` bit 4 is 0 (fixed priority), the lowest-numbered eligible channel wins. Channel 0 is the highest and the last channel is the lowest.
- R4: A channel whose `sw_req` bit is set is eligible in the same way as one whose `dreq` bit is set.
- R5: A channel whose `mask` bit is 1 is never granted, whether its request comes from `dreq` or from `sw_req`.
- R6: Bit i of `req_status` equals `dreq[i] | sw_req[i]`, whatever the values of `mask` and of the command byte.
- R7: While `cmd_byte` bit 2 is 1, no new grant is issued. Once the bit clears, pending eligible requests are granted.
- R8: A grant appears on the clock edge after an idle cycle in which an eligible request is present. It then stays unchanged, whatever the requests do, until `svc_done` is sampled high.
- R9: When `cmd_byte` bit 4 is 1 (rotating priority), the search for a winner starts at the channel after the one granted last, so the channel just served becomes the lowest priority. The start point advances on every grant, in either mode.
- R10: The edge that samples `svc_done` high while a grant is held clears `grant` and `grant_valid`. The earliest next grant comes one edge later. With no eligible request, the arbiter stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_byte | input | CMD_W | Command byte; bit 2 disables the controller, bit 4 selects rotating priority |
| dreq | input | N_CH | Hardware request per channel |
| sw_req | input | N_CH | Software request bit per channel |
| mask | input | N_CH | Mask bit per channel; 1 blocks the channel |
| svc_done | input | 1 | Transfer engine reports that the current service is complete |
| grant | output | N_CH | One-hot grant to the winning channel |
| grant_valid | output | 1 | A grant is held |
| req_status | output | N_CH | Raw request per channel, for the status register |

## Verification
The bench drives a request pattern with every channel asking, which shows whether fixed order or rotation is in force. It also drives single-channel patterns from hardware only and from software only, which show whether both sources reach the arbiter. Masked requests are driven next to unmasked ones, so the bench can tell gating apart from plain absence of requests, while the status output shows the raw bits. Raising a higher-priority request during a held grant, and setting the disable bit with a request pending, separate holding and suppression from the normal decision path. The expected winners in rotating mode come from a rank-based model that follows the pointer history from reset onward.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CMD_DIS_BIT = 2;
  localparam int CMD_ROT_BIT = 4;

  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;
endpackage

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0] dreq,
  input  logic [N_CH-1:0] sw_req,
  input  logic [N_CH-1:0] mask,
  output logic [N_CH-1:0] raw_req,
  output logic [N_CH-1:0] elig_req
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign raw_req[c]  = dreq[c] | sw_req[c];
    assign elig_req[c] = raw_req[c] & ~mask[c];
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N_CH = 4,
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] elig,
  input  logic [IW-1:0]   base,
  output logic [IW-1:0]   win,
  output logic            any
);
  // Circular search from base; the lowest offset with a request wins.
  function automatic logic [IW:0] circ_search(input logic [N_CH-1:0] r,
                                              input logic [IW-1:0] b);
    logic [IW:0] res;
    int idx;
    res = '0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      idx = int'(b) + k;
      if (idx >= N_CH) idx = idx - N_CH;
      if (r[idx]) res = {1'b1, IW'(idx)};
    end
    return res;
  endfunction

  logic [IW:0] found;
  assign found = circ_search(elig, base);
  assign any   = found[IW];
  assign win   = found[IW-1:0];
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic [N_CH-1:0]  dreq,
  input  logic [N_CH-1:0]  sw_req,
  input  logic [N_CH-1:0]  mask,
  input  logic             svc_done,
  output logic [N_CH-1:0]  grant,
  output logic             grant_valid,
  output logic [N_CH-1:0]  req_status
);
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1;

  function automatic logic [IW-1:0] advance(input logic [IW-1:0] idx);
    return (int'(idx) == N_CH - 1) ? '0 : IW'(int'(idx) + 1);
  endfunction

  logic [N_CH-1:0] raw_req, elig_req;
  logic [N_CH-1:0] grant_q;
  logic            busy_q;
  logic [IW-1:0]   base_q, pick_base, pick_idx;
  logic            pick_any;
  logic            ctl_off;
  prio_mode_e      mode;
  logic            issue_evt, done_evt;

  dma_req_gate #(.N_CH(N_CH)) u_gate (
    .dreq    (dreq),
    .sw_req  (sw_req),
    .mask    (mask),
    .raw_req (raw_req),
    .elig_req(elig_req)
  );

  assign ctl_off   = cmd_byte[CMD_DIS_BIT];
  assign mode      = cmd_byte[CMD_ROT_BIT] ? PRIO_ROTATE : PRIO_FIXED;
  assign pick_base = (mode == PRIO_ROTATE) ? base_q : '0;

  dma_prio_pick #(.N_CH(N_CH)) u_pick (
    .elig(elig_req),
    .base(pick_base),
    .win (pick_idx),
    .any (pick_any)
  );

  assign issue_evt = !busy_q && !ctl_off && pick_any;
  assign done_evt  = busy_q && svc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
      base_q  <= '0;
    end else if (issue_evt) begin
      busy_q  <= 1'b1;
      grant_q <= N_CH'(1) << pick_idx;
      base_q  <= advance(pick_idx);
    end else if (done_evt) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = busy_q;
  assign req_status  = raw_req;
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CMD_W-1:0] cmd_byte,
  input logic [N_CH-1:0]  dreq,
  input logic [N_CH-1:0]  sw_req,
  input logic [N_CH-1:0]  mask,
  input logic             svc_done,
  input logic [N_CH-1:0]  grant,
  input logic             grant_valid
);
  logic [N_CH-1:0] elig_v;
  assign elig_v = (dreq | sw_req) & ~mask;

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !svc_done) |=> (grant_valid && $stable(grant)));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && svc_done) |=> !grant_valid);

  a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && cmd_byte[CMD_DIS_BIT]) |=> !grant_valid);

  a_r5_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |=> (!grant_valid || ((grant & $past(elig_v)) != '0)));

  a_r3_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && !cmd_byte[CMD_DIS_BIT] && !cmd_byte[CMD_ROT_BIT] && elig_v[0])
      |=> grant[0]);
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.N_CH(N_CH), .CMD_W(CMD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_byte   (cmd_byte),
  .dreq       (dreq),
  .sw_req     (sw_req),
  .mask       (mask),
  .svc_done   (svc_done),
  .grant      (grant),
  .grant_valid(grant_valid)
);

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    cmd_byte = '0;
  logic [NC-1:0] dreq = '0, sw_req = '0, mask = '0;
  logic          svc_done = 1'b0;
  logic [NC-1:0] grant;
  logic          grant_valid;
  logic [NC-1:0] req_status;

  int n_checks = 0;
  int n_fail = 0;
  int m_base = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arbiter #(.N_CH(NC), .CMD_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .dreq(dreq),
    .sw_req(sw_req), .mask(mask), .svc_done(svc_done), .grant(grant),
    .grant_valid(grant_valid), .req_status(req_status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Rank model: the channel with the smallest distance from the start point wins.
  function automatic int model_pick(input logic [NC-1:0] elig, input int start);
    int best = -1;
    int best_rank = NC;
    for (int ch = 0; ch < NC; ch++) begin
      int rank = (ch - start + NC) % NC;
      if (elig[ch] && rank < best_rank) begin
        best = ch;
        best_rank = rank;
      end
    end
    return best;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_grant(input string tag, input int ch);
    tick();
    chk({tag, " grant"}, int'(grant), 1 << ch);
    chk({tag, " valid"}, int'(grant_valid), 1);
    m_base = (ch + 1) % NC;
  endtask

  task automatic finish_svc(input string tag);
    svc_done = 1'b1;
    tick();
    svc_done = 1'b0;
    chk({tag, " R10 released"}, int'(grant_valid), 0);
    chk({tag, " R10 grant cleared"}, int'(grant), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset grant", int'(grant), 0);
    chk("R1 reset valid", int'(grant_valid), 0);
    chk("R6 reset status", int'(req_status), 0);
  endtask

  task automatic t_fixed();
    cmd_byte = 8'h00;
    dreq = 4'hF;
    expect_grant("R3 fixed all", 0);
    finish_svc("R3 a");
    expect_grant("R3 fixed repeat ch0", 0);
    finish_svc("R3 b");
    dreq = 4'hC;
    expect_grant("R3 fixed upper pair", 2);
    dreq = 4'h0;
    finish_svc("R3 c");
  endtask

  task automatic t_mask();
    dreq = 4'h1; mask = 4'h1;
    tick();
    chk("R5 masked dreq no grant", int'(grant_valid), 0);
    chk("R6 status ignores mask", int'(req_status), 1);
    dreq = 4'h0; sw_req = 4'h1;
    tick();
    chk("R5 masked sw_req no grant", int'(grant_valid), 0);
    sw_req = 4'h0; dreq = 4'h3;
    expect_grant("R5 unmasked neighbour", 1);
    dreq = 4'h0; mask = 4'h0;
    finish_svc("R5");
  endtask

  task automatic t_sw();
    sw_req = 4'h8;
    expect_grant("R4 sw only", 3);
    finish_svc("R4 a");
    sw_req = 4'h2; dreq = 4'h4;
    expect_grant("R4 sw beats lower dreq", 1);
    sw_req = 4'h0; dreq = 4'h0;
    finish_svc("R4 b");
  endtask

  task automatic t_disable();
    cmd_byte = 8'h04;
    dreq = 4'h4;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R7 disabled no grant", int'(grant_valid), 0);
    end
    chk("R6 status while disabled", int'(req_status), 4);
    cmd_byte = 8'h00;
    expect_grant("R7 re-enabled", 2);
    dreq = 4'h0;
    finish_svc("R7");
  endtask

  task automatic t_hold();
    dreq = 4'h2;
    expect_grant("R8 initial", 1);
    dreq = 4'h3;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8 held grant", int'(grant), 2);
    end
    finish_svc("R8");
    expect_grant("R8 next decision", 0);
    dreq = 4'h0;
    finish_svc("R8 b");
  endtask

  task automatic t_rotate();
    cmd_byte = 8'h10;
    dreq = 4'hF;
    for (int i = 0; i < 5; i++) begin
      int exp_ch = model_pick(4'hF, m_base);
      expect_grant("R9 rotating all", exp_ch);
      finish_svc("R9");
    end
    dreq = 4'h5;
    begin
      int exp_ch = model_pick(4'h5, m_base);
      expect_grant("R9 rotating sparse", exp_ch);
    end
    dreq = 4'h0;
    finish_svc("R9 b");
    cmd_byte = 8'h00;
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10 idle stays idle", int'(grant_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_mask();
    t_sw();
    t_disable();
    t_hold();
    t_rotate();
    t_idle();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule